// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the address generator and transfer counter of a single DMA channel. It keeps a current and a base copy of a 16-bit transfer address and of a 16-bit transfer count. A host loads and reads these registers through an 8-bit register port, one byte per access. A shared byte pointer decides whether an access reaches the low byte or the high byte.

Each transfer strobe moves the address by one byte-width step, either up or down. It also reduces the count by the same step. The step is 1 in byte mode and 2 in word mode. In word mode the address output always presents an even address. When the count wraps below zero, the engine raises a one-cycle terminal-count flag. When an end-of-process occurs and autoinitialize is on, the engine restores both current registers from their base copies.

When this channel is the source of a memory-to-memory move, an address-hold input can keep its address fixed. Bus cycle timing and request arbitration belong to the surrounding controller. The host port is a plain register interface with no flow control: every access completes in the cycle it is presented.

Top module: `dmaeng_chan`

## Requirements
- R1: Each transfer strobe changes the current address by the step, modulo 2^16. The step is 1 when `wide_mode` is 0 and 2 when it is 1. The address goes up when `dir_down` is 0 and down when it is 1. The result is visible on the clock edge that samples the strobe.
- R2: While `wide_mode` is 1, bit 0 of `addr_out` is 0, and the other bits follow the current address. A host read still returns the current address with the programmed bit 0 unchanged.
- R3: In byte mode each strobe lowers the current count by 1. A programmed count n therefore gives n+1 strobes up to and including the one that produces terminal count.
- R4: In word mode each strobe lowers the current count by 2. A programmed count n gives n/2+1 strobes for an even n and (n+1)/2 strobes for an odd n.
- R5: `tc` is high for exactly one cycle, in the cycle after a strobe whose count wraps: 0 to FFFFh in byte mode, and 0 to FFFEh or 1 to FFFFh in word mode.
- R6: With `autoinit_en` at 0, the count after terminal count holds its wrapped value. That value is FFFFh in byte mode, FFFEh in word mode from an even count, and FFFFh in word mode from an odd count.
- R7: With `autoinit_en` at 1, an end-of-process restores the current address and current count from their base copies, and no step is applied in that cycle. An end-of-process is either a strobe that produces terminal count or a cycle with `eop_in` at 1. With `autoinit_en` at 0, `eop_in` changes neither register.
- R8: While both `addr_hold` and `mem2mem` are 1, a strobe leaves the current address unchanged but still steps the count. `addr_hold` alone has no effect.
- R9: A host write puts `host_wdata` into the addressed byte of both the base and the current register. A host read returns the addressed byte of the current register on `host_rdata`, combinationally. `host_sel` = 0 selects the address register and 1 selects the count register. Pointer value 0 selects bits 7:0 and 1 selects bits 15:8.
- R10: The byte pointer advances after every read or write access and wraps from 1 to 0. Reset and `ptr_clear` set it to 0, and `ptr_clear` wins over an access in the same cycle. The access in that cycle still uses the old pointer value.
- R11: In a cycle with `host_wr_en` at 1, `xfer_stb` and `eop_in` are ignored.
- R12: After reset, both address registers and both count registers are 0, `tc` is 0 and the byte pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host byte write |
| host_rd_en | input | 1 | Host byte read (advances the pointer) |
| host_sel | input | 1 | 0 = address register, 1 = count register |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Selected byte of the selected current register |
| ptr_clear | input | 1 | Return the byte pointer to the low byte |
| xfer_stb | input | 1 | One transfer completed |
| wide_mode | input | 1 | 1 = word transfers (step 2), 0 = byte transfers |
| dir_down | input | 1 | 1 = address decrements |
| addr_hold | input | 1 | Keep the address fixed (with mem2mem) |
| mem2mem | input | 1 | Channel is the memory-to-memory source |
| eop_in | input | 1 | External end-of-process |
| autoinit_en | input | 1 | Reload from base copies on end-of-process |
| addr_out | output | 16 | Current address, bit 0 forced low in word mode |
| count_out | output | 16 | Current count |
| tc | output | 1 | Terminal-count pulse |

## Verification
The bench builds the engine with its default parameters: a 16-bit address, a 16-bit count and an 8-bit host port. With these widths a sweep of every programmed count from 0 to 40, in both byte and word mode, covers both parities. It also covers the zero count and both wrap targets. Address runs start at 0000h, 0001h, 7FFFh, FFFEh and FFFFh in all four width and direction combinations, so every carry and borrow across the 16-bit boundary is reached. The pointer tests cover an odd number of accesses and a clear that arrives in the same cycle as an access.

// File: rtl/dmaeng_pkg.sv
package dmaeng_pkg;

  typedef enum logic {
    SEL_ADDR  = 1'b0,
    SEL_COUNT = 1'b1
  } host_sel_e;

  // Transfer step in bytes for the given width mode.
  function automatic logic [1:0] step_size(input logic wide);
    return wide ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/dmaeng_byteptr.sv
module dmaeng_byteptr #(
  parameter int NB = 2,
  localparam int PW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [PW-1:0] ptr_q
);

  localparam logic [PW-1:0] LAST = PW'(NB - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (clr) begin
      ptr_q <= '0;
    end else if (adv) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

endmodule

// File: rtl/dmaeng_regpair.sv
module dmaeng_regpair #(
  parameter int W  = 16,
  parameter int BW = 8,
  parameter int PW = 1,
  localparam int NB = W / BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [BW-1:0] wr_data,
  input  logic          upd_en,
  input  logic [W-1:0]  upd_val,
  input  logic          reload_en,
  output logic [W-1:0]  cur_q,
  output logic [W-1:0]  base_q
);

  logic [NB-1:0] byte_we;
  logic [W-1:0]  cur_d;
  logic [W-1:0]  base_d;

  for (genvar b = 0; b < NB; b++) begin : g_byte_we
    assign byte_we[b] = wr_en && (wr_idx == PW'(b));
  end

  always_comb begin
    base_d = base_q;
    cur_d  = cur_q;
    if (reload_en) begin
      cur_d = base_q;
    end else if (upd_en) begin
      cur_d = upd_val;
    end
    for (int b = 0; b < NB; b++) begin
      if (byte_we[b]) begin
        base_d[b*BW +: BW] = wr_data;
        cur_d[b*BW +: BW]  = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      base_q <= '0;
    end else begin
      cur_q  <= cur_d;
      base_q <= base_d;
    end
  end

endmodule

// File: rtl/dmaeng_stepper.sv
module dmaeng_stepper
  import dmaeng_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          wide,
  input  logic          down,
  input  logic [AW-1:0] addr_cur,
  input  logic [CW-1:0] cnt_cur,
  output logic [AW-1:0] addr_nxt,
  output logic [CW-1:0] cnt_nxt,
  output logic          cnt_wrap
);

  logic [AW-1:0] a_step;
  logic [CW-1:0] c_step;

  assign a_step   = AW'(step_size(wide));
  assign c_step   = CW'(step_size(wide));
  assign addr_nxt = down ? (addr_cur - a_step) : (addr_cur + a_step);
  assign cnt_nxt  = cnt_cur - c_step;
  // The count wraps when it is smaller than the step it loses.
  assign cnt_wrap = (cnt_cur < c_step);

endmodule

// File: rtl/dmaeng_chan.sv
module dmaeng_chan
  import dmaeng_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int HOST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic              host_sel,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  input  logic              ptr_clear,
  input  logic              xfer_stb,
  input  logic              wide_mode,
  input  logic              dir_down,
  input  logic              addr_hold,
  input  logic              mem2mem,
  input  logic              eop_in,
  input  logic              autoinit_en,
  output logic [ADDR_W-1:0] addr_out,
  output logic [CNT_W-1:0]  count_out,
  output logic              tc
);

  localparam int NB = ADDR_W / HOST_W;
  localparam int PW = (NB > 1) ? $clog2(NB) : 1;
  localparam int MW = (ADDR_W > CNT_W) ? ADDR_W : CNT_W;

  host_sel_e sel_e;
  logic [PW-1:0]     ptr_q;
  logic              access;
  logic              do_xfer;
  logic              eop_evt;
  logic              reload;
  logic              addr_upd;
  logic [ADDR_W-1:0] addr_cur;
  logic [ADDR_W-1:0] addr_base;
  logic [ADDR_W-1:0] addr_nxt;
  logic [CNT_W-1:0]  cnt_cur;
  logic [CNT_W-1:0]  cnt_base;
  logic [CNT_W-1:0]  cnt_nxt;
  logic              cnt_wrap;
  logic              tc_q;
  logic [MW-1:0]     rd_word;

  assign sel_e    = host_sel_e'(host_sel);
  assign access   = host_wr_en || host_rd_en;
  assign do_xfer  = xfer_stb && !host_wr_en;
  assign eop_evt  = !host_wr_en && (eop_in || (do_xfer && cnt_wrap));
  assign reload   = eop_evt && autoinit_en;
  assign addr_upd = do_xfer && !(addr_hold && mem2mem);

  dmaeng_byteptr #(.NB(NB)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ptr_clear),
    .adv   (access),
    .ptr_q (ptr_q)
  );

  dmaeng_stepper #(.AW(ADDR_W), .CW(CNT_W)) u_step (
    .wide     (wide_mode),
    .down     (dir_down),
    .addr_cur (addr_cur),
    .cnt_cur  (cnt_cur),
    .addr_nxt (addr_nxt),
    .cnt_nxt  (cnt_nxt),
    .cnt_wrap (cnt_wrap)
  );

  dmaeng_regpair #(.W(ADDR_W), .BW(HOST_W), .PW(PW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (host_wr_en && (sel_e == SEL_ADDR)),
    .wr_idx    (ptr_q),
    .wr_data   (host_wdata),
    .upd_en    (addr_upd),
    .upd_val   (addr_nxt),
    .reload_en (reload),
    .cur_q     (addr_cur),
    .base_q    (addr_base)
  );

  dmaeng_regpair #(.W(CNT_W), .BW(HOST_W), .PW(PW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (host_wr_en && (sel_e == SEL_COUNT)),
    .wr_idx    (ptr_q),
    .wr_data   (host_wdata),
    .upd_en    (do_xfer),
    .upd_val   (cnt_nxt),
    .reload_en (reload),
    .cur_q     (cnt_cur),
    .base_q    (cnt_base)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q <= 1'b0;
    end else begin
      tc_q <= do_xfer && cnt_wrap;
    end
  end

  // Word transfers present only even addresses.
  always_comb begin
    addr_out    = addr_cur;
    addr_out[0] = addr_cur[0] && !wide_mode;
  end

  assign count_out  = cnt_cur;
  assign tc         = tc_q;
  assign rd_word    = (sel_e == SEL_COUNT) ? MW'(cnt_cur) : MW'(addr_cur);
  assign host_rdata = HOST_W'(rd_word >> (int'(ptr_q) * HOST_W));

  // The base copies are only read back through a reload.
  logic unused_base;
  assign unused_base = ^{addr_base, cnt_base};

endmodule

// File: rtl/dmaeng_chan_chk.sv
module dmaeng_chan_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr_en,
  input logic              xfer_stb,
  input logic              wide_mode,
  input logic              dir_down,
  input logic              addr_hold,
  input logic              mem2mem,
  input logic              eop_in,
  input logic              autoinit_en,
  input logic [ADDR_W-1:0] addr_out,
  input logic [CNT_W-1:0]  count_out,
  input logic              tc
);

  logic              pv;
  logic              p_quiet;
  logic              p_xfer;
  logic              p_held;
  logic              p_wide;
  logic              p_down;
  logic              p_noauto;
  logic [ADDR_W-1:0] p_addr;
  logic [CNT_W-1:0]  p_cnt;
  logic [ADDR_W-1:0] a_mask;
  logic [ADDR_W-1:0] a_step;
  logic [CNT_W-1:0]  c_step;
  logic [ADDR_W-1:0] a_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv       <= 1'b0;
      p_quiet  <= 1'b0;
      p_xfer   <= 1'b0;
      p_held   <= 1'b0;
      p_wide   <= 1'b0;
      p_down   <= 1'b0;
      p_noauto <= 1'b0;
      p_addr   <= '0;
      p_cnt    <= '0;
    end else begin
      pv       <= 1'b1;
      p_xfer   <= xfer_stb && !host_wr_en;
      p_quiet  <= xfer_stb && !host_wr_en && !eop_in && !autoinit_en;
      p_held   <= addr_hold && mem2mem;
      p_wide   <= wide_mode;
      p_down   <= dir_down;
      p_noauto <= !autoinit_en;
      p_addr   <= addr_out;
      p_cnt    <= count_out;
    end
  end

  assign a_mask = wide_mode ? ~ADDR_W'(1) : '1;
  assign a_step = p_wide ? ADDR_W'(2) : ADDR_W'(1);
  assign c_step = p_wide ? CNT_W'(2) : CNT_W'(1);
  assign a_exp  = (p_down ? (p_addr - a_step) : (p_addr + a_step)) & a_mask;

  // R1: a free strobe moves the address by one step
  p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && p_quiet && !p_held && (p_wide == wide_mode)) |-> (addr_out == a_exp));

  // R2: even addresses only in word mode
  p_even_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wide_mode |-> !addr_out[0]);

  // R3, R4: a free strobe lowers the count by one step
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && p_quiet) |-> (count_out == p_cnt - c_step));

  // R5: terminal count only follows a strobe that wrapped
  p_tc_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (pv && p_xfer && (p_cnt < c_step)));

  // R6: byte mode count is all ones after terminal count
  p_tc_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && p_noauto && !p_wide) |-> (count_out == '1));

  // R8: held address does not move
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && p_quiet && p_held && (p_wide == wide_mode)) |-> (addr_out == p_addr));

endmodule

bind dmaeng_chan dmaeng_chan_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/dmaeng_chan_bench.sv
module dmaeng_chan_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic        host_rd_en = 1'b0;
  logic        host_sel = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        ptr_clear = 1'b0;
  logic        xfer_stb = 1'b0;
  logic        wide_mode = 1'b0;
  logic        dir_down = 1'b0;
  logic        addr_hold = 1'b0;
  logic        mem2mem = 1'b0;
  logic        eop_in = 1'b0;
  logic        autoinit_en = 1'b0;
  logic [15:0] addr_out;
  logic [15:0] count_out;
  logic        tc;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  dmaeng_chan u_dmaeng_chan (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hwrite(input bit sel, input logic [15:0] v);
    host_sel = sel; host_wr_en = 1'b1;
    host_wdata = v[7:0];  tick();
    host_wdata = v[15:8]; tick();
    host_wr_en = 1'b0;
  endtask

  task automatic hread(input bit sel, output logic [15:0] v);
    host_sel = sel; host_rd_en = 1'b1;
    #1 v[7:0] = host_rdata;  tick();
    #1 v[15:8] = host_rdata; tick();
    host_rd_en = 1'b0;
  endtask

  task automatic strobe();
    xfer_stb = 1'b1; tick(); xfer_stb = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] rv;
    logic [15:0] starts [5] = '{16'h0000, 16'h0001, 16'h7FFF, 16'hFFFE, 16'hFFFF};
    @(negedge clk); @(negedge clk);
    // R12 reset state
    check(addr_out == 0, "R12 addr", addr_out, 0);
    check(count_out == 0, "R12 count", count_out, 0);
    check(tc == 0, "R12 tc", tc, 0);
    rst_n = 1'b1;
    tick();

    // R9 write then read back both registers
    hwrite(1'b0, 16'h1234);
    hwrite(1'b1, 16'hA5C3);
    hread(1'b0, rv);
    check(rv == 16'h1234, "R9 addr readback", rv, 16'h1234);
    hread(1'b1, rv);
    check(rv == 16'hA5C3, "R9 count readback", rv, 16'hA5C3);
    check(addr_out == 16'h1234, "R9 addr port", addr_out, 16'h1234);

    // R10 pointer clear after a lone byte
    hwrite(1'b0, 16'h0000);
    host_sel = 1'b0; host_wr_en = 1'b1; host_wdata = 8'hAB; tick(); host_wr_en = 1'b0;
    check(addr_out == 16'h00AB, "R10 lone low byte", addr_out, 16'h00AB);
    ptr_clear = 1'b1; tick(); ptr_clear = 1'b0;
    hwrite(1'b0, 16'hEFCD);
    check(addr_out == 16'hEFCD, "R10 clear", addr_out, 16'hEFCD);
    // R10 a read advances the shared pointer
    host_rd_en = 1'b1; tick(); host_rd_en = 1'b0;
    host_wr_en = 1'b1; host_wdata = 8'h5A; tick(); host_wr_en = 1'b0;
    check(addr_out == 16'h5ACD, "R10 shared pointer", addr_out, 16'h5ACD);
    // R10 clear wins over a same-cycle access
    host_rd_en = 1'b1; ptr_clear = 1'b1; tick(); host_rd_en = 1'b0; ptr_clear = 1'b0;
    hread(1'b0, rv);
    check(rv == 16'h5ACD, "R10 clear over access", rv, 16'h5ACD);

    // R1 / R2 address sweep
    for (int w = 0; w < 2; w++) begin
      for (int d = 0; d < 2; d++) begin
        for (int s = 0; s < 5; s++) begin
          logic [15:0] raw;
          wide_mode = w[0]; dir_down = d[0];
          hwrite(1'b0, starts[s]);
          hwrite(1'b1, 16'h0100);
          raw = starts[s];
          for (int i = 0; i < 3; i++) begin
            logic [15:0] ex;
            strobe();
            raw = d[0] ? raw - 16'(w + 1) : raw + 16'(w + 1);
            ex = w[0] ? (raw & 16'hFFFE) : raw;
            check(addr_out == ex, w[0] ? "R2 word addr" : "R1 byte addr", addr_out, ex);
          end
          hread(1'b0, rv);
          check(rv == raw, "R2 raw readback", rv, raw);
        end
      end
    end
    dir_down = 1'b0;

    // R3 / R4 / R5 / R6 count sweep
    for (int w = 0; w < 2; w++) begin
      for (int n = 0; n <= 40; n++) begin
        int k;
        int exp_k;
        logic [15:0] fill;
        wide_mode = w[0];
        hwrite(1'b1, 16'(n));
        k = 0;
        while (k < 200) begin
          strobe();
          k++;
          if (tc) break;
          check(count_out == 16'(n - k * (w + 1)), w[0] ? "R4 count step" : "R3 count step",
                count_out, 16'(n - k * (w + 1)));
        end
        exp_k = w[0] ? ((n % 2 == 0) ? n / 2 + 1 : (n + 1) / 2) : n + 1;
        check(k == exp_k, w[0] ? "R4 transfers" : "R3 transfers", k, exp_k);
        fill = (w[0] && (n % 2 == 0)) ? 16'hFFFE : 16'hFFFF;
        check(count_out == fill, "R6 wrapped count", count_out, fill);
        tick();
        check(tc == 0, "R5 single pulse", tc, 0);
      end
    end
    wide_mode = 1'b0;

    // R8 address hold
    hwrite(1'b0, 16'h0500);
    hwrite(1'b1, 16'h0010);
    addr_hold = 1'b1; mem2mem = 1'b1;
    strobe(); strobe();
    check(addr_out == 16'h0500, "R8 held addr", addr_out, 16'h0500);
    check(count_out == 16'h000E, "R8 count moves", count_out, 16'h000E);
    mem2mem = 1'b0;
    strobe();
    check(addr_out == 16'h0501, "R8 hold alone", addr_out, 16'h0501);
    addr_hold = 1'b0;

    // R7 eop without autoinit changes nothing
    eop_in = 1'b1; tick(); eop_in = 1'b0;
    check(addr_out == 16'h0501, "R7 eop no autoinit addr", addr_out, 16'h0501);
    check(count_out == 16'h000D, "R7 eop no autoinit count", count_out, 16'h000D);

    // R7 autoinit on terminal count
    autoinit_en = 1'b1;
    hwrite(1'b0, 16'h0100);
    hwrite(1'b1, 16'h0002);
    strobe(); strobe(); strobe();
    check(tc == 1, "R7 tc with autoinit", tc, 1);
    check(count_out == 16'h0002, "R7 count reload", count_out, 2);
    check(addr_out == 16'h0100, "R7 addr reload", addr_out, 16'h0100);
    // R7 external eop reload
    strobe();
    check(addr_out == 16'h0101, "R7 step before eop", addr_out, 16'h0101);
    eop_in = 1'b1; tick(); eop_in = 1'b0;
    check(addr_out == 16'h0100, "R7 eop addr reload", addr_out, 16'h0100);
    check(count_out == 16'h0002, "R7 eop count reload", count_out, 2);
    // R7 eop with a strobe reloads without stepping
    strobe();
    eop_in = 1'b1; xfer_stb = 1'b1; tick(); eop_in = 1'b0; xfer_stb = 1'b0;
    check(addr_out == 16'h0100, "R7 eop+strobe addr", addr_out, 16'h0100);
    check(count_out == 16'h0002, "R7 eop+strobe count", count_out, 2);
    autoinit_en = 1'b0;

    // R11 strobes and eop ignored during host writes
    xfer_stb = 1'b1; eop_in = 1'b1;
    hwrite(1'b1, 16'h0010);
    xfer_stb = 1'b0; eop_in = 1'b0;
    check(count_out == 16'h0010, "R11 count", count_out, 16'h0010);
    check(addr_out == 16'h0100, "R11 addr", addr_out, 16'h0100);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule